// File: doc/BRIEF.md
# Keyboard Matrix Scan Port

This peripheral sits between a processor's register bus and the wires of a keyboard matrix with up to 18 column drivers and 8 row sense lines. Firmware runs the scan itself. It writes a column pattern: all columns released, all populated columns pulled low, or one column pulled low to probe it. It then reads back which rows see a pressed key.

Row lines are active low and are pulled up outside the block. They pass through a two-stage synchronizer before any logic uses them. Each row has a change detector that catches both edges. A detected change sets a sticky per-row pending flag. The flags are merged into one interrupt, which wakes the firmware scan task when it is enabled.

A separate column-2 helper output follows the logical level of column 2. This lets a board with an inverting buffer on that line keep it consistent with the matrix. A control field also selects a stronger push-up drive for the column pins.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset all 18 column outputs and the column-2 helper are high, the control register reads 0, all pending flags read 0, the interrupt is low and the strong-drive output is low.
- R2: A 16-bit read at byte address 0x4 returns the pressed-row bitmap in bits 7:0, with a bit set where the row input is low, and zeros in bits 15:8. A row change appears in this bitmap no earlier than two clocks after it reaches the input, because of the synchronizer.
- R3: A write to address 0x6 sets columns 15..0 from data bits 15..0. The outputs change on the clock after the write, and the register reads back the written value.
- R4: A write to address 0x8 sets columns 17..16 from data bits 1..0. The other data bits are ignored, and a readback shows zeros in bits 15:2.
- R5: The column-2 helper output is low exactly when column 2 is driven low: when all columns are selected, or when column 2 alone is probed. It is high in every other case.
- R6: A falling edge or a rising edge on row r sets pending bit r, readable at address 0xC, within three clocks.
- R7: Writing a one to bit r at address 0xC clears pending bit r. Zero bits leave their flags unchanged. A change event in the same cycle as the clear keeps the bit set.
- R8: The interrupt output is high exactly when control bit 0 (interrupt enable) is 1 and at least one pending bit is set.
- R9: At address 0x0 the control register holds bit 0 (interrupt enable) and bits 7:6 (column drive mode). The other bits read 0. The strong-drive output is high only when the drive mode is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of a 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| col_out | output | 18 | Column drive levels, 0 = pulled low |
| col2_aux | output | 1 | Separate column-2 helper level |
| col_hidrive | output | 1 | Strong push-up drive select for columns |
| row_in_n | input | 8 | Row sense lines, active low |
| irq | output | 1 | Merged row-change interrupt |

## Verification
A row edge can set a pending flag in the same clock in which firmware writes a one to clear that flag. The bench changes a row, waits until the synchronized edge reaches the detector, and times a clear write so that it lands on exactly that edge. It judges the result by reading the flag back: set-wins means it must still read 1, and a second clear must then remove it. Around this case the bench sweeps every row pattern, every single-column probe and both edge directions on every row.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam logic [3:0] ADDR_CTRL  = 4'h0;
  localparam logic [3:0] ADDR_ROWS  = 4'h4;
  localparam logic [3:0] ADDR_COLLO = 4'h6;
  localparam logic [3:0] ADDR_COLHI = 4'h8;
  localparam logic [3:0] ADDR_PEND  = 4'hC;
  localparam logic [1:0] DRIVE_STRONG = 2'b01;
endpackage

// File: rtl/kbs_row_sync.sv
module kbs_row_sync #(
  parameter int NROW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] row_in_n,
  input  logic            clr_en,
  input  logic [NROW-1:0] clr_mask,
  output logic [NROW-1:0] pressed,
  output logic [NROW-1:0] pend
);
  logic [NROW-1:0] s1_q, s2_q, prev_q, pend_q;
  logic [NROW-1:0] edge_hit, pend_d;

  always_comb begin
    edge_hit = s2_q ^ prev_q;
    pend_d   = pend_q;
    if (clr_en) pend_d = pend_d & ~clr_mask;
    pend_d = pend_d | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      s1_q   <= row_in_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign pressed = ~s2_q;
  assign pend    = pend_q;

  // R6: a detected edge always leaves its flag set on the next clock
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));
  // R7: without a clear, flags never drop
  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/kbs_col_reg.sv
module kbs_col_reg #(
  parameter int NCOL = 18,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [NCOL-1:0] col_q,
  output logic            col2_q
);
  localparam int CHI = NCOL - DW;

  logic [NCOL-1:0] col_d;
  logic            col2_d;
  logic            col_en;

  always_comb begin
    col_en = wr_lo | wr_hi;
    col_d  = col_q;
    if (wr_lo) col_d[DW-1:0]    = wdata;
    if (wr_hi) col_d[NCOL-1:DW] = wdata[CHI-1:0];
    col2_d = col_d[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '1;
      col2_q <= 1'b1;
    end else if (col_en) begin
      col_q  <= col_d;
      col2_q <= col2_d;
    end
  end

  // R3: low write lands on columns 15..0
  assert_col_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (col_q[DW-1:0] == $past(wdata)));
  // R4: high write lands on top columns only
  assert_col_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (col_q[NCOL-1:DW] == $past(wdata[CHI-1:0])) && $stable(col_q[DW-1:0]));
  // R5: helper tracks column 2
  assert_col2_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col2_q == col_q[2]);
endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan #(
  parameter int NCOL = 18,
  parameter int NROW = 8,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NCOL-1:0] col_out,
  output logic            col2_aux,
  output logic            col_hidrive,
  input  logic [NROW-1:0] row_in_n,
  output logic            irq
);
  import kbs_pkg::*;
  localparam int CHI = NCOL - DW;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic wr_ctrl, wr_lo, wr_hi, wr_pend;
  always_comb begin
    wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    wr_lo   = bus_sel && bus_wr && (bus_addr == ADDR_COLLO);
    wr_hi   = bus_sel && bus_wr && (bus_addr == ADDR_COLHI);
    wr_pend = bus_sel && bus_wr && (bus_addr == ADDR_PEND);
  end

  logic       ien_q, ien_d;
  logic [1:0] drv_q, drv_d;
  always_comb begin
    ien_d = bus_wdata[0];
    drv_d = bus_wdata[7:6];
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ien_q <= 1'b0;
      drv_q <= 2'b00;
    end else if (wr_ctrl) begin
      ien_q <= ien_d;
      drv_q <= drv_d;
    end
  end

  logic [NROW-1:0] pressed, pend;

  kbs_row_sync #(.NROW(NROW)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .row_in_n (row_in_n),
    .clr_en   (wr_pend),
    .clr_mask (bus_wdata[NROW-1:0]),
    .pressed  (pressed),
    .pend     (pend)
  );

  kbs_col_reg #(.NCOL(NCOL), .DW(DW)) u_cols (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wdata  (bus_wdata),
    .col_q  (col_out),
    .col2_q (col2_aux)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL:  bus_rdata = {{(DW-8){1'b0}}, drv_q, 5'b0, ien_q};
      ADDR_ROWS:  bus_rdata = {{(DW-NROW){1'b0}}, pressed};
      ADDR_COLLO: bus_rdata = col_out[DW-1:0];
      ADDR_COLHI: bus_rdata = {{(DW-CHI){1'b0}}, col_out[NCOL-1:DW]};
      ADDR_PEND:  bus_rdata = {{(DW-NROW){1'b0}}, pend};
      default:    bus_rdata = '0;
    endcase
  end

  assign col_hidrive = (drv_q == DRIVE_STRONG);
  assign irq         = ien_q & (|pend);

  // R9: a control write is reflected in the stored enable on the next clock
  assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_ctrl |=> (ien_q == $past(bus_wdata[0])));
  // R8: interrupt needs a pending flag to be set
  assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> (pend != '0));
endmodule

// File: tb/kbd_matrix_scan_tb_top.sv
module kbd_matrix_scan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [17:0] col_out;
  logic        col2_aux, col_hidrive, irq;
  logic [7:0]  row_in_n = 8'hFF;

  int n_checks = 0, n_fail = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  kbd_matrix_scan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .col_out(col_out), .col2_aux(col2_aux), .col_hidrive(col_hidrive),
    .row_in_n(row_in_n), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 cols", col_out, 18'h3FFFF);
    check("R1 col2", col2_aux, 1'b1);
    check("R1 irq", irq, 1'b0);
    check("R1 hidrive", col_hidrive, 1'b0);
    rd(4'h0, rv); check("R1 ctrl", rv, 16'h0);
    rd(4'hC, rv); check("R1 pend", rv, 16'h0);

    // R2 sweep all row patterns
    for (int p = 0; p < 256; p++) begin
      row_in_n = p[7:0];
      idle(3);
      rd(4'h4, rv);
      check("R2 pressed", rv, {8'h00, ~p[7:0]});
    end
    row_in_n = 8'hFF;
    idle(4);
    wr(4'hC, 16'h00FF);
    rd(4'hC, rv); check("R7 clear all", rv, 16'h0);

    // R3/R4/R5 single-column probes
    for (int c = 0; c < 18; c++) begin
      logic [17:0] m;
      m = ~(18'h1 << c);
      wr(4'h6, m[15:0]);
      wr(4'h8, {14'h3FFF, m[17:16]});
      check(c < 16 ? "R3 probe" : "R4 probe", col_out, m);
      check("R5 col2 aux", col2_aux, (c == 2) ? 1'b0 : 1'b1);
      rd(4'h8, rv); check("R4 hi readback", rv, {14'h0, m[17:16]});
      rd(4'h6, rv); check("R3 lo readback", rv, m[15:0]);
    end
    // R5 all selected then none
    wr(4'h6, 16'h0000); wr(4'h8, 16'h0000);
    check("R5 all low", {col2_aux, col_out}, 19'h0);
    wr(4'h6, 16'hFFFF); wr(4'h8, 16'hFFFF);
    check("R5 none", {col2_aux, col_out}, {1'b1, 18'h3FFFF});

    // R6 both edges on every row
    for (int r = 0; r < 8; r++) begin
      row_in_n = ~(8'h1 << r);
      idle(4);
      rd(4'hC, rv); check("R6 fall", rv, 16'h1 << r);
      wr(4'hC, 16'h1 << r);
      rd(4'hC, rv); check("R7 clr", rv, 16'h0);
      row_in_n = 8'hFF;
      idle(4);
      rd(4'hC, rv); check("R6 rise", rv, 16'h1 << r);
      wr(4'hC, 16'h00FF);
    end

    // R7 zero bits leave flags; set wins over clear
    row_in_n = 8'hF6; idle(4);
    wr(4'hC, 16'h0001);
    rd(4'hC, rv); check("R7 partial", rv, 16'h0008);
    wr(4'hC, 16'h0008);
    row_in_n = 8'hFF;            // edge on rows 0 and 3
    @(negedge clk); @(negedge clk);
    wr(4'hC, 16'h0009);          // lands on the setting clock
    rd(4'hC, rv); check("R7 set wins", rv, 16'h0009);
    wr(4'hC, 16'h0009);
    rd(4'hC, rv); check("R7 cleared", rv, 16'h0);

    // R8 gating
    row_in_n = 8'h7F; idle(4);
    check("R8 disabled", irq, 1'b0);
    wr(4'h0, 16'h0001);
    check("R8 enabled", irq, 1'b1);
    wr(4'hC, 16'h0080);
    check("R8 cleared", irq, 1'b0);
    row_in_n = 8'hFF; idle(4);
    check("R8 rise", irq, 1'b1);
    wr(4'hC, 16'h00FF);

    // R9 control fields
    for (int f = 0; f < 4; f++) begin
      wr(4'h0, 16'hFF3E | (f[1:0] << 6));
      rd(4'h0, rv); check("R9 ctrl rb", rv, {8'h0, f[1:0], 6'h0});
      check("R9 hidrive", col_hidrive, (f == 1) ? 1'b1 : 1'b0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule